// File: doc/BRIEF.md
# Two-Road Traffic Light Controller

This block sequences the lights of a crossing where two roads, A and B, meet. Each road has a presence sensor that reads 1 while vehicles wait or pass. The controller gives green to one road for as long as that road's sensor stays high. It then shows yellow on that road for exactly one clock and hands green to the other road. The road that is not green or yellow always shows red.

The controller is a four-state Moore machine. Both light codes come from the state register alone, so a sensor that changes between clock edges never reaches the lamps until the next rising edge. A synchronous active-high reset returns the crossing to A green, B red from any state. A parameter selects how the next-state logic is built: as the two reduced flip-flop equations, or as a readable case table. Both forms give the same behaviour.

Top module: `tlc_two_road`

## Requirements
- R1: On a rising clock edge with `rst` high, the lights become A green and B red (`lamp_a`=00, `lamp_b`=10), whatever state the controller was in.
- R2: Lamp codes are green=00, yellow=01, red=10. The code 11 never appears on either lamp output.
- R3: While A is green, a high `sense_a` keeps A green across the next edge.
- R4: While A is green, a low `sense_a` turns A yellow (01), with B still red, at the next edge.
- R5: A yellow lasts exactly one cycle. The next edge gives A red and B green, whatever the sensors read.
- R6: While B is green, a high `sense_b` keeps B green, and a low `sense_b` turns B yellow (01) at the next edge, with A still red.
- R7: B yellow lasts exactly one cycle. The next edge gives A green and B red, whatever the sensors read.
- R8: At least one of the two lamps is red in every cycle, so both roads are never green or yellow together.
- R9: `sense_b` has no effect while A is green, and `sense_a` has no effect while B is green.
- R10: Lamp outputs change only at rising clock edges. A sensor change between edges leaves them unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sense_a | input | 1 | Road A traffic present |
| sense_b | input | 1 | Road B traffic present |
| lamp_a | output | 2 | Road A light code (00 green, 01 yellow, 10 red) |
| lamp_b | output | 2 | Road B light code (00 green, 01 yellow, 10 red) |

## Verification
The hardest cases to reach from the ports are a sensor that moves between edges and a reset that lands in the middle of a B phase. After every input change that follows a falling edge, the stimulus probes the lamps before the next rising edge. This shows that the change has not reached the outputs early. The run also parks the controller in B green and then raises reset. It drives sensor values into both yellow states that would matter if those states honoured them, so the one-cycle yellow and the return to A green are each seen against contrary inputs.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int STATE_W = 2;
  localparam int LAMP_W  = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_A_GO   = 2'b00,
    ST_A_WARN = 2'b01,
    ST_B_GO   = 2'b10,
    ST_B_WARN = 2'b11
  } tlc_state_e;

  typedef enum logic [LAMP_W-1:0] {
    LAMP_GO   = 2'b00,
    LAMP_WARN = 2'b01,
    LAMP_STOP = 2'b10
  } lamp_e;
endpackage

// File: rtl/tlc_step.sv
module tlc_step
  import tlc_pkg::*;
#(
  parameter bit EQUATION_FORM = 1'b1
) (
  input  logic [STATE_W-1:0] cur,
  input  logic               sense_a,
  input  logic               sense_b,
  output logic [STATE_W-1:0] nxt
);
  generate
    if (EQUATION_FORM) begin : g_eq
      // reduced flip-flop input equations for the fixed state encoding
      always_comb begin
        nxt[1] = cur[1] ^ cur[0];
        nxt[0] = (~cur[1] & ~cur[0] & ~sense_a) | (cur[1] & ~cur[0] & ~sense_b);
      end
    end else begin : g_tab
      always_comb begin
        case (cur)
          ST_A_GO:   nxt = sense_a ? ST_A_GO : ST_A_WARN;
          ST_A_WARN: nxt = ST_B_GO;
          ST_B_GO:   nxt = sense_b ? ST_B_GO : ST_B_WARN;
          default:   nxt = ST_A_GO;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/tlc_lamp_map.sv
module tlc_lamp_map
  import tlc_pkg::*;
(
  input  logic [STATE_W-1:0] st,
  output logic [LAMP_W-1:0]  lamp_a,
  output logic [LAMP_W-1:0]  lamp_b
);
  always_comb begin
    lamp_a = {st[1], ~st[1] & st[0]};
    lamp_b = {~st[1], st[1] & st[0]};
  end
endmodule

// File: rtl/tlc_two_road.sv
module tlc_two_road
  import tlc_pkg::*;
#(
  parameter bit EQUATION_FORM = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sense_a,
  input  logic              sense_b,
  output logic [LAMP_W-1:0] lamp_a,
  output logic [LAMP_W-1:0] lamp_b
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic [LAMP_W-1:0]  la_d;
  logic [LAMP_W-1:0]  lb_d;

  tlc_step #(.EQUATION_FORM(EQUATION_FORM)) u_step (
    .cur     (state_q),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .nxt     (state_d)
  );

  // lamps decoded from the next state and registered with it
  tlc_lamp_map u_map (
    .st     (state_d),
    .lamp_a (la_d),
    .lamp_b (lb_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_A_GO;
      lamp_a  <= LAMP_GO;
      lamp_b  <= LAMP_STOP;
    end else begin
      state_q <= state_d;
      lamp_a  <= la_d;
      lamp_b  <= lb_d;
    end
  end
endmodule

// File: rtl/tlc_two_road_chk.sv
module tlc_two_road_chk (
  input logic       clk,
  input logic       rst,
  input logic       sense_a,
  input logic       sense_b,
  input logic [1:0] lamp_a,
  input logic [1:0] lamp_b
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (lamp_a == 2'b00 && lamp_b == 2'b10));

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    (lamp_a != 2'b11) && (lamp_b != 2'b11));

  assert_a_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == 2'b00 && sense_a) |=> (lamp_a == 2'b00));

  assert_a_warn_R4: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == 2'b00 && !sense_a) |=> (lamp_a == 2'b01 && lamp_b == 2'b10));

  assert_a_warn_once_R5: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == 2'b01) |=> (lamp_a == 2'b10 && lamp_b == 2'b00));

  assert_b_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == 2'b00 && sense_b) |=> (lamp_b == 2'b00));

  assert_b_warn_R6: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == 2'b00 && !sense_b) |=> (lamp_b == 2'b01 && lamp_a == 2'b10));

  assert_b_warn_once_R7: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == 2'b01) |=> (lamp_a == 2'b00 && lamp_b == 2'b10));

  assert_one_red_R8: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == 2'b10) || (lamp_b == 2'b10));
endmodule

bind tlc_two_road tlc_two_road_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .sense_a (sense_a),
  .sense_b (sense_b),
  .lamp_a  (lamp_a),
  .lamp_b  (lamp_b)
);

// File: tb/tlc_two_road_bench.sv
`timescale 1ns/1ps
module tlc_two_road_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sense_a = 1'b0;
  logic       sense_b = 1'b0;
  logic [1:0] lamp_a;
  logic [1:0] lamp_b;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tlc_two_road u_tlc_two_road (
    .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
    .lamp_a(lamp_a), .lamp_b(lamp_b)
  );

  function automatic logic [3:0] lights_of(input int s);
    case (s)
      0:       return {2'b00, 2'b10};
      1:       return {2'b01, 2'b10};
      2:       return {2'b10, 2'b00};
      default: return {2'b10, 2'b01};
    endcase
  endfunction

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got a=%b b=%b expected a=%b b=%b", tag,
               got[3:2], got[1:0], exp[3:2], exp[1:0]);
    end
  endtask

  // driver: set inputs after a falling edge, advance the model, queue the expected lights
  task automatic drive(input logic sa, input logic sb, input string tag);
    @(negedge clk);
    rst = 1'b0;
    sense_a = sa;
    sense_b = sb;
    #1;
    check({lamp_a, lamp_b}, lights_of(model), "R10 mid-cycle");
    case (model)
      0: model = sa ? 0 : 1;
      1: model = 2;
      2: model = sb ? 2 : 3;
      default: model = 0;
    endcase
    exp_q.push_back(lights_of(model));
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input logic sa, input logic sb);
    @(negedge clk);
    rst = 1'b1;
    sense_a = sa;
    sense_b = sb;
    model = 0;
    exp_q.push_back(lights_of(0));
    tag_q.push_back("R1 reset");
  endtask

  // monitor: shortly after each rising edge, compare against the oldest queued item
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({lamp_a, lamp_b}, e, t);
      check({(lamp_a == 2'b11 || lamp_b == 2'b11), 3'b000}, 4'b0000, "R2 code 11");
      check({!(lamp_a == 2'b10 || lamp_b == 2'b10), 3'b000}, 4'b0000, "R8 one red");
    end
  end

  initial begin
    #80000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0, 1'b0);
    drive(1'b1, 1'b0, "R3 hold A");
    drive(1'b1, 1'b1, "R9 sense_b ignored in A green");
    drive(1'b1, 1'b0, "R9 sense_b toggled in A green");
    drive(1'b0, 1'b1, "R4 A to yellow");
    drive(1'b1, 1'b0, "R5 A yellow one cycle");
    drive(1'b0, 1'b1, "R6 hold B");
    drive(1'b1, 1'b1, "R9 sense_a ignored in B green");
    drive(1'b0, 1'b1, "R9 sense_a toggled in B green");
    drive(1'b1, 1'b0, "R6 B to yellow");
    drive(1'b0, 1'b1, "R7 B yellow one cycle");
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b0, "R4 free run A");
      drive(1'b0, 1'b0, "R5 free run");
      drive(1'b0, 1'b0, "R6 free run B");
      drive(1'b0, 1'b0, "R7 free run");
    end
    drive(1'b0, 1'b1, "R4 to A yellow");
    drive(1'b0, 1'b1, "R5 to B green");
    do_reset(1'b0, 1'b1);
    drive(1'b1, 1'b1, "R3 after reset");
    drive(1'b0, 1'b0, "R4 after reset");
    drive(1'b1, 1'b0, "R5 after reset");
    drive(1'b0, 1'b0, "R6 after reset");
    do_reset(1'b1, 1'b1);
    drive(1'b0, 1'b0, "R4 after reset from B yellow");
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule